// File: doc/BRIEF.md
# Two-Rank Crosspoint Routing Configuration Store

This block holds the routing configuration for a crosspoint switch with 17 outputs. Each output owns a 7-bit entry. The top bit turns that output's driver on, and the lower six bits name the input that feeds it. A host programs entries one at a time into a staging rank through a parallel port. One update strobe then moves the whole staging rank into the active rank, which drives the switch. All outputs therefore change routing in the same clock cycle.

The host can read back the active rank over a data bus that is modelled as separate in, out and output-enable signals. A global disable pin, active low, clears every output enable at once without waiting for a clock. It also ignores chip select. It never touches the staging rank, so a single update after the disable restores the staged routing.

The host port is a register-style strobe interface, not a data stream. There is no valid/ready pairing and no back-pressure: every qualified strobe is taken in the clock cycle in which it is sampled.

Top module: `xpcfg_dual_rank`

## Requirements
- R1: Output i is driven by active entry i. `out_en[i]` is bit 6 of the entry, and `out_sel[6*i+5:6*i]` is bits 5:0.
- R2: At a rising clock edge with `cs_n` and `we_n` both low, `din` is stored into the staging entry at `addr`. The active rank does not change.
- R3: At a rising clock edge with `cs_n` and `upd_n` both low, all 17 staging entries are copied into the active rank together. If a write happens in the same cycle, the copy takes the staging contents from before that write.
- R4: `dout_oe` is high exactly when `cs_n` and `re_n` are both low. While it is high, `dout` shows the active entry at `addr` combinationally. While it is low, `dout` is zero.
- R5: Read and write may be asserted together. Readback then shows the active entry, and the write lands only in the staging rank.
- R6: While `cs_n` is high, no write or update changes any stored data, and `dout_oe` stays low.
- R7: While `rst_n` is low, every `out_en` bit is zero without waiting for a clock edge, whatever `cs_n` and the other pins are doing. An update during that time still copies the select fields, but the enables stay zero.
- R8: `rst_n` leaves the staging rank unchanged. An update after `rst_n` is released restores the staged enables.
- R9: Writes to addresses 17 to 31 are ignored. Readback at those addresses returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global output disable, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Staging write strobe, active low |
| re_n | input | 1 | Readback enable, active low |
| upd_n | input | 1 | Staging-to-active update strobe, active low |
| addr | input | 5 | Entry address |
| din | input | 7 | Write data from the host |
| dout | output | 7 | Readback data |
| dout_oe | output | 1 | Readback bus drive enable |
| out_sel | output | 102 | Input select for each output, 6 bits each |
| out_en | output | 17 | Driver enable for each output |

## Verification
The assertions check four things on every cycle:
- An update copies the staging rank into the active rank.
- A qualified write lands in its staging entry.
- A deselected chip leaves the active rank unchanged.
- The enables stay clear while the disable pin is low, and out-of-range reads return zero.

Only the bench scenarios can show the following:
- The immediate, clockless clearing of the enables between clock edges.
- A disable followed by an update restoring the staged enables.
- The staging copy being taken from before a write in the same cycle.
- Correct readback while read and write overlap.

// File: rtl/xpcfg_pkg.sv
package xpcfg_pkg;
  localparam int NUM_OUT = 17;
  localparam int ADDR_W  = 5;
  localparam int SEL_W   = 6;
  localparam int ENTRY_W = SEL_W + 1;
endpackage

// File: rtl/xpcfg_stage.sv
module xpcfg_stage #(
  parameter int NUM_OUT = 17,
  parameter int ADDR_W  = 5,
  parameter int ENTRY_W = 7
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [ENTRY_W-1:0]         din,
  output logic [NUM_OUT*ENTRY_W-1:0] stage_flat
);
  // Staging rank: never reset, contents undefined until written.
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_ent
    logic [ENTRY_W-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && addr == ADDR_W'(i)) q <= din;
    end
    assign stage_flat[i*ENTRY_W +: ENTRY_W] = q;

    // R2
    wr_land_chk: assert property (@(posedge clk)
      (wr_en && addr == ADDR_W'(i)) |=> (q == $past(din)));
  end

  // R9
  oor_write_chk: assert property (@(posedge clk)
    (wr_en && int'(addr) >= NUM_OUT) |=> $stable(stage_flat));
endmodule

// File: rtl/xpcfg_active.sv
module xpcfg_active #(
  parameter int NUM_OUT = 17,
  parameter int SEL_W   = 6,
  localparam int ENTRY_W = SEL_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       upd,
  input  logic [NUM_OUT*ENTRY_W-1:0] stage_flat,
  output logic [NUM_OUT*SEL_W-1:0]   sel_flat,
  output logic [NUM_OUT-1:0]         en
);
  logic [NUM_OUT*SEL_W-1:0] stage_sel;
  logic [NUM_OUT-1:0]       stage_en;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_ent
    assign stage_sel[i*SEL_W +: SEL_W] = stage_flat[i*ENTRY_W +: SEL_W];
    assign stage_en[i]                 = stage_flat[i*ENTRY_W + SEL_W];

    // Select field: clocked only, unaffected by the global disable.
    always_ff @(posedge clk) begin
      if (upd) sel_flat[i*SEL_W +: SEL_W] <= stage_sel[i*SEL_W +: SEL_W];
    end

    // Enable bit: cleared asynchronously by the global disable.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   en[i] <= 1'b0;
      else if (upd) en[i] <= stage_en[i];
    end
  end

  // R3
  upd_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (sel_flat == $past(stage_sel)) && (en == $past(stage_en)));

  // R7
  en_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (en == '0));

  // R7
  upd_in_reset_chk: assert property (@(posedge clk)
    (upd && !rst_n) |=> (sel_flat == $past(stage_sel)));
endmodule

// File: rtl/xpcfg_readback.sv
module xpcfg_readback #(
  parameter int NUM_OUT = 17,
  parameter int ADDR_W  = 5,
  parameter int SEL_W   = 6,
  localparam int ENTRY_W = SEL_W + 1
) (
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NUM_OUT*SEL_W-1:0] sel_flat,
  input  logic [NUM_OUT-1:0]       en,
  output logic [ENTRY_W-1:0]       dout,
  output logic                     dout_oe
);
  assign dout_oe = rd_en;

  always_comb begin
    dout = '0;
    if (rd_en) begin
      for (int i = 0; i < NUM_OUT; i++) begin
        if (addr == ADDR_W'(i)) dout = {en[i], sel_flat[i*SEL_W +: SEL_W]};
      end
    end
  end

  always_comb begin
    if (int'(addr) >= NUM_OUT) begin
      // R9
      oor_read_chk: assert (dout == '0);
    end
  end
endmodule

// File: rtl/xpcfg_dual_rank.sv
module xpcfg_dual_rank
  import xpcfg_pkg::*;
#(
  parameter int N_OUT  = NUM_OUT,
  parameter int A_W    = ADDR_W,
  parameter int S_W    = SEL_W,
  localparam int E_W   = S_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               we_n,
  input  logic               re_n,
  input  logic               upd_n,
  input  logic [A_W-1:0]     addr,
  input  logic [E_W-1:0]     din,
  output logic [E_W-1:0]     dout,
  output logic               dout_oe,
  output logic [N_OUT*S_W-1:0] out_sel,
  output logic [N_OUT-1:0]   out_en
);
  logic wr_en, upd, rd_en;
  logic [N_OUT*E_W-1:0] stage_flat;

  assign wr_en = !cs_n && !we_n;
  assign upd   = !cs_n && !upd_n;
  assign rd_en = !cs_n && !re_n;

  xpcfg_stage #(.NUM_OUT(N_OUT), .ADDR_W(A_W), .ENTRY_W(E_W)) u_stage (
    .clk(clk), .wr_en(wr_en), .addr(addr), .din(din), .stage_flat(stage_flat)
  );

  xpcfg_active #(.NUM_OUT(N_OUT), .SEL_W(S_W)) u_active (
    .clk(clk), .rst_n(rst_n), .upd(upd), .stage_flat(stage_flat),
    .sel_flat(out_sel), .en(out_en)
  );

  xpcfg_readback #(.NUM_OUT(N_OUT), .ADDR_W(A_W), .SEL_W(S_W)) u_rdbk (
    .rd_en(rd_en), .addr(addr), .sel_flat(out_sel), .en(out_en),
    .dout(dout), .dout_oe(dout_oe)
  );

  // R6
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(out_sel) && $stable(out_en));

  // R6
  cs_oe_chk: assert property (@(posedge clk) cs_n |-> !dout_oe);
endmodule

// File: tb/tb_xpcfg_dual_rank.sv
module tb_xpcfg_dual_rank;
  localparam int N = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b1, cs_n = 1'b1, we_n = 1'b1, re_n = 1'b1, upd_n = 1'b1;
  logic [4:0] addr = '0;
  logic [6:0] din = '0;
  logic [6:0] dout;
  logic dout_oe;
  logic [N*6-1:0] out_sel;
  logic [N-1:0] out_en;

  int nvec = 0, nfail = 0;
  logic [6:0] stg_m [N];
  bit         stg_k [N];
  logic [6:0] act_m [N];
  bit         act_k [N];

  always #5 clk = ~clk;

  xpcfg_dual_rank dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .re_n(re_n),
    .upd_n(upd_n), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .out_sel(out_sel), .out_en(out_en)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] all_en_exp();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = act_m[i][6];
    return v;
  endfunction

  task automatic check_state(string tag);
    for (int i = 0; i < N; i++) begin
      if (act_k[i]) chk({out_en[i], out_sel[i*6 +: 6]} == act_m[i], tag,
                        {out_en[i], out_sel[i*6 +: 6]}, act_m[i]);
    end
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic cycle(bit cs, bit we, bit re, bit up, bit rs,
                       logic [4:0] a, logic [6:0] d);
    bit exp_oe;
    cs_n = cs; we_n = we; re_n = re; upd_n = up; rst_n = rs;
    addr = a; din = d;
    if (!rs) for (int i = 0; i < N; i++) act_m[i][6] = 1'b0;
    #1;
    exp_oe = !cs && !re;
    chk(dout_oe == exp_oe, "R4", dout_oe, exp_oe);
    if (!exp_oe)           chk(dout == 7'd0, "R4", dout, 0);
    else if (a >= 5'd17)   chk(dout == 7'd0, "R9", dout, 0);
    else if (act_k[a])     chk(dout == act_m[a], "R4", dout, act_m[a]);
    if (!rs)               chk(out_en == '0, "R7", out_en, 0);
    @(posedge clk);
    if (!cs && !up) begin
      for (int i = 0; i < N; i++) begin
        act_m[i] = stg_m[i];
        act_k[i] = stg_k[i];
      end
    end
    if (!cs && !we && a < 5'd17) begin
      stg_m[a] = d;
      stg_k[a] = 1'b1;
    end
    if (!rs) for (int i = 0; i < N; i++) act_m[i][6] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0417));
    for (int i = 0; i < N; i++) begin
      stg_k[i] = 1'b0;
      act_k[i] = 1'b0;
      stg_m[i] = 'x;
      act_m[i] = 'x;
    end
    @(negedge clk);

    // R7: reset state, enables cleared at once, with chip deselected
    rst_n = 1'b0;
    #1 chk(out_en == '0, "R7", out_en, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: fill the staging rank with enables set, active not yet changed
    for (int i = 0; i < N; i++) cycle(0, 0, 1, 1, 1, 5'(i), {1'b1, 6'(i + 3)});
    chk(out_en == '0, "R2", out_en, 0);

    // R1: update and check every output
    cycle(0, 1, 1, 0, 1, 5'd0, 7'd0);
    check_state("R1");
    chk(out_en == {N{1'b1}}, "R1", out_en, {N{1'b1}});

    // R3: write and update in one cycle copies the older staging value
    cycle(0, 0, 1, 0, 1, 5'd4, 7'h15);
    check_state("R3");
    chk(out_sel[4*6 +: 6] == 6'd7, "R3", out_sel[4*6 +: 6], 7);
    cycle(0, 1, 1, 0, 1, 5'd0, 7'd0);
    chk(out_sel[4*6 +: 6] == 6'h15 && !out_en[4], "R3", {out_en[4], out_sel[4*6 +: 6]}, 7'h15);

    // R5: read and write together at address 3
    cycle(0, 0, 0, 1, 1, 5'd3, 7'h2a);
    check_state("R5");
    cycle(0, 1, 0, 0, 1, 5'd3, 7'd0);
    cycle(0, 1, 0, 1, 1, 5'd3, 7'd0);
    chk(act_m[3] == 7'h2a, "R5", act_m[3], 7'h2a);

    // R6: deselected chip ignores write and update, bus released
    cycle(1, 0, 0, 0, 1, 5'd5, 7'h00);
    check_state("R6");
    chk(dout_oe == 1'b0, "R6", dout_oe, 0);

    // R9: out-of-range write ignored, readback returns zero
    cycle(0, 0, 1, 1, 1, 5'd20, 7'h7f);
    cycle(0, 1, 0, 0, 1, 5'd20, 7'd0);
    check_state("R9");
    cycle(0, 1, 0, 1, 1, 5'd31, 7'd0);

    // R8: disable, then an update restores the staged enables
    cycle(1, 1, 1, 1, 0, 5'd0, 7'd0);
    check_state("R7");
    cycle(0, 1, 1, 0, 1, 5'd0, 7'd0);
    check_state("R8");
    chk(out_en == all_en_exp(), "R8", out_en, all_en_exp());

    // R7: update while disabled copies selects only
    cycle(0, 1, 1, 0, 0, 5'd0, 7'd0);
    check_state("R7");
    chk(out_en == '0, "R7", out_en, 0);

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      bit cs, we, re, up, rs;
      cs = ($urandom % 100) >= 85;
      we = $urandom % 2;
      re = $urandom % 2;
      up = ($urandom % 100) >= 15;
      rs = ($urandom % 100) >= 3;
      cycle(cs, we, re, up, rs, 5'($urandom), 7'($urandom));
      check_state("R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule